// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads a page directory and then one page table from memory. Pages are 4 KB. Linear bits 31..22 select one of 1024 directory entries. Bits 21..12 select one of 1024 entries in the page table that the directory entry points to. Bits 11..0 pass through unchanged as the byte offset. When paging is switched off, the linear address comes back unchanged and no memory is touched.

A requester presents a linear address with a write flag and a user flag. The walker reads the entries over a simple single-word memory master port. It sets the accessed bit in each entry that lacks it. On a write it also sets the dirty bit in the page-table entry. It applies the user/supervisor and read/write rights of both levels, keeping the more restrictive of the two. It then returns either the physical address or a fault. A fault carries a code that tells a missing page apart from a rights violation. The faulting linear address is latched in a fault-address register.

Only one walk is in flight at a time. The request port stays not-ready until the response has been taken.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o`=1, `rsp_valid_o`=0, `mem_req_o`=0 and `fault_addr_o`=0.
- R2: With `paging_en_i`=0, a request is answered with `rsp_paddr_o` equal to the linear address, no fault and no memory access. The response is visible in the cycle right after acceptance.
- R3: The directory base register holds a 20-bit frame number written through `base_we_i`/`base_wdata_i`. The directory entry is read at {base frame, linear[31:22], 2'b00}.
- R4: The page-table entry is read at {directory entry[31:12], linear[21:12], 2'b00}. A successful response returns {table entry[31:12], linear[11:0]}.
- R5: Entry fields are P at bit 0, R/W at bit 1, U/S at bit 2, A at bit 5, D at bit 6 and frame at bits 31..12. Every other bit is preserved on write-back.
- R6: If the directory entry or the table entry has P=0, the walk ends with a fault whose code bit 0 is 0, and no further memory access follows.
- R7: A supervisor access (user=0) is always allowed. A user access needs U/S=1 in both entries, and a user write also needs R/W=1 in both. A violation gives a fault with code bit 0 set, and the table entry is not written.
- R8: Fault code bit 1 is the write flag and bit 2 is the user flag; on success the code is 0. `fault_addr_o` takes the faulting linear address and holds it until the next fault.
- R9: A directory entry with A=0 is written back with A set, before the table read. A permitted access whose table entry has A=0, or which is a write with D=0, writes the table entry back with A set, and with D set on a write.
- R10: The sequence is directory read, optional directory write-back, table read, optional table write-back, response. With W wait cycles per memory access, the response appears steps×(W+1) cycles after acceptance.
- R11: `req_ready_o` is low from acceptance until the response is taken. A request offered meanwhile is ignored. The response fields hold steady while `rsp_ready_i` is low.
- R12: A memory request keeps its address, write enable and write data steady until `mem_ready_i` completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| paging_en_i | input | 1 | 1 = translate, 0 = pass through |
| base_we_i | input | 1 | Load the directory base register |
| base_wdata_i | input | 20 | Directory frame number |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Walker idle, request taken this cycle |
| req_laddr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from the user level |
| mem_req_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | Pending access is a write |
| mem_addr_o | output | 32 | Entry byte address |
| mem_wdata_o | output | 32 | Entry write-back data |
| mem_ready_i | input | 1 | Memory completes the access this cycle |
| mem_rdata_i | input | 32 | Entry read data, valid with mem_ready_i |
| rsp_valid_o | output | 1 | Response available |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_fcode_o | output | 3 | {user, write, protection} |
| fault_addr_o | output | 32 | Last faulting linear address |

## Verification
A pass-through response is due in the first cycle after the accepting edge. A translated response is due one cycle later for each memory step that the bench predicts from the entry bits, multiplied by one plus the wait states. The bench counts clock edges from acceptance to `rsp_valid_o`, samples on falling edges, and compares that count exactly with the prediction. It logs every completed memory access at the port and compares the address, direction and write data in order against the predicted walk. The hold checks sample during each cycle that `rsp_ready_i` is held low. The ignored request is checked as no new memory access during the two cycles after release.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned BIT_P  = 0;
  localparam int unsigned BIT_RW = 1;
  localparam int unsigned BIT_US = 2;
  localparam int unsigned BIT_A  = 5;
  localparam int unsigned BIT_D  = 6;

  typedef enum logic [2:0] {
    WALK_IDLE,
    WALK_DIR_RD,
    WALK_DIR_WB,
    WALK_TBL_RD,
    WALK_TBL_WB,
    WALK_RSP
  } walk_state_e;

  typedef struct packed {
    logic user;
    logic write;
    logic prot;
  } fault_code_t;
endpackage

// File: rtl/pw_dir_base.sv
module pw_dir_base #(
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [FRAME_W-1:0] wdata_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   frame_q <= '0;
    else if (we_i) frame_q <= wdata_i;
  end

  assign frame_o = frame_q;

  // R3
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> frame_o == $past(wdata_i));
endmodule

// File: rtl/pw_rights.sv
module pw_rights #(
  parameter int unsigned LEVELS = 2
) (
  input  logic              user_i,
  input  logic              write_i,
  input  logic [LEVELS-1:0] us_i,
  input  logic [LEVELS-1:0] rw_i,
  output logic              allow_o
);
  logic [LEVELS-1:0] lvl_ok;

  // every level must grant user access; the most restrictive level wins
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign lvl_ok[g] = us_i[g] & (~write_i | rw_i[g]);
  end

  assign allow_o = ~user_i | (&lvl_ok);

  // R7
  always_comb begin
    if (!user_i) sup_allow_chk: assert (allow_o);
  end
endmodule

// File: rtl/pw_walker.sv
module pw_walker import pw_pkg::*; #(
  parameter  int unsigned IDX_W  = 10,
  localparam int unsigned OFF_W  = IDX_W + 2,
  localparam int unsigned ADDR_W = 2 * IDX_W + OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    paging_en_i,
  input  logic [ADDR_W-OFF_W-1:0] base_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_laddr_i,
  input  logic                    req_write_i,
  input  logic                    req_user_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [ADDR_W-1:0]       mem_wdata_o,
  input  logic                    mem_ready_i,
  input  logic [ADDR_W-1:0]       mem_rdata_i,
  output logic                    rsp_valid_o,
  input  logic                    rsp_ready_i,
  output logic [ADDR_W-1:0]       rsp_paddr_o,
  output logic                    rsp_fault_o,
  output fault_code_t             rsp_fcode_o,
  output logic [ADDR_W-1:0]       fault_addr_o
);
  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] laddr_q, pde_q, pte_q, paddr_q, paddr_d, fault_addr_q;
  logic [ADDR_W-1:0] dir_wb, tbl_wb;
  logic              write_q, user_q, fault_q;
  fault_code_t       fcode_q;
  logic              fault_set, fault_prot, pa_set;
  logic              allow, need_wb, ent_p, mem_done;

  assign mem_done = mem_req_o & mem_ready_i;
  assign ent_p    = mem_rdata_i[BIT_P];
  assign need_wb  = ~mem_rdata_i[BIT_A] | (write_q & ~mem_rdata_i[BIT_D]);

  pw_rights #(.LEVELS(2)) u_rights (
    .user_i  (user_q),
    .write_i (write_q),
    .us_i    ({pde_q[BIT_US], mem_rdata_i[BIT_US]}),
    .rw_i    ({pde_q[BIT_RW], mem_rdata_i[BIT_RW]}),
    .allow_o (allow)
  );

  always_comb begin
    dir_wb = pde_q;
    dir_wb[BIT_A] = 1'b1;
    tbl_wb = pte_q;
    tbl_wb[BIT_A] = 1'b1;
    if (write_q) tbl_wb[BIT_D] = 1'b1;
  end

  always_comb begin
    state_d    = state_q;
    fault_set  = 1'b0;
    fault_prot = 1'b0;
    pa_set     = 1'b0;
    paddr_d    = '0;
    unique case (state_q)
      WALK_IDLE: if (req_valid_i) begin
        if (paging_en_i) state_d = WALK_DIR_RD;
        else begin
          state_d = WALK_RSP;
          pa_set  = 1'b1;
          paddr_d = req_laddr_i;
        end
      end
      WALK_DIR_RD: if (mem_ready_i) begin
        if (!ent_p) begin
          state_d   = WALK_RSP;
          fault_set = 1'b1;
        end else if (!mem_rdata_i[BIT_A]) state_d = WALK_DIR_WB;
        else state_d = WALK_TBL_RD;
      end
      WALK_DIR_WB: if (mem_ready_i) state_d = WALK_TBL_RD;
      WALK_TBL_RD: if (mem_ready_i) begin
        if (!ent_p || !allow) begin
          state_d    = WALK_RSP;
          fault_set  = 1'b1;
          fault_prot = ent_p;
        end else begin
          state_d = need_wb ? WALK_TBL_WB : WALK_RSP;
          pa_set  = 1'b1;
          paddr_d = {mem_rdata_i[ADDR_W-1:OFF_W], laddr_q[OFF_W-1:0]};
        end
      end
      WALK_TBL_WB: if (mem_ready_i) state_d = WALK_RSP;
      WALK_RSP:    if (rsp_ready_i) state_d = WALK_IDLE;
      default:     state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= WALK_IDLE;
      laddr_q      <= '0;
      write_q      <= 1'b0;
      user_q       <= 1'b0;
      pde_q        <= '0;
      pte_q        <= '0;
      paddr_q      <= '0;
      fault_q      <= 1'b0;
      fcode_q      <= '0;
      fault_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == WALK_IDLE && req_valid_i) begin
        laddr_q <= req_laddr_i;
        write_q <= req_write_i;
        user_q  <= req_user_i;
      end
      if (state_q == WALK_DIR_RD && mem_ready_i) pde_q <= mem_rdata_i;
      if (state_q == WALK_TBL_RD && mem_ready_i) pte_q <= mem_rdata_i;
      if (pa_set) begin
        paddr_q <= paddr_d;
        fault_q <= 1'b0;
        fcode_q <= '0;
      end
      if (fault_set) begin
        paddr_q      <= '0;
        fault_q      <= 1'b1;
        fcode_q      <= '{user: user_q, write: write_q, prot: fault_prot};
        fault_addr_q <= laddr_q;
      end
    end
  end

  assign req_ready_o = (state_q == WALK_IDLE);
  assign mem_req_o   = (state_q == WALK_DIR_RD) || (state_q == WALK_DIR_WB) ||
                       (state_q == WALK_TBL_RD) || (state_q == WALK_TBL_WB);
  assign mem_we_o    = (state_q == WALK_DIR_WB) || (state_q == WALK_TBL_WB);

  always_comb begin
    if (state_q == WALK_DIR_RD || state_q == WALK_DIR_WB)
      mem_addr_o = {base_i, laddr_q[ADDR_W-1 -: IDX_W], 2'b00};
    else
      mem_addr_o = {pde_q[ADDR_W-1:OFF_W], laddr_q[OFF_W+IDX_W-1:OFF_W], 2'b00};
    unique case (state_q)
      WALK_DIR_WB: mem_wdata_o = dir_wb;
      WALK_TBL_WB: mem_wdata_o = tbl_wb;
      default:     mem_wdata_o = '0;
    endcase
  end

  assign rsp_valid_o  = (state_q == WALK_RSP);
  assign rsp_paddr_o  = paddr_q;
  assign rsp_fault_o  = fault_q;
  assign rsp_fcode_o  = fcode_q;
  assign fault_addr_o = fault_addr_q;

  // R12
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));
  // R11
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) &&
                                    $stable(rsp_fault_o) && $stable(rsp_fcode_o));
  // R11
  one_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o && !mem_req_o);
  // R9
  wb_sets_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[BIT_A]);
  // R6
  np_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_done && !mem_we_o && !mem_rdata_i[BIT_P] |=> !mem_req_o && rsp_valid_o && rsp_fault_o);
  // R4
  offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_paddr_o[OFF_W-1:0] == laddr_q[OFF_W-1:0]);
  // R8
  fault_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> fault_addr_o == laddr_q);
endmodule

// File: rtl/pt_walker.sv
module pt_walker import pw_pkg::*; #(
  parameter  int unsigned IDX_W   = 10,
  localparam int unsigned OFF_W   = IDX_W + 2,
  localparam int unsigned ADDR_W  = 2 * IDX_W + OFF_W,
  localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               paging_en_i,
  input  logic               base_we_i,
  input  logic [FRAME_W-1:0] base_wdata_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_laddr_i,
  input  logic               req_write_i,
  input  logic               req_user_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [ADDR_W-1:0]  mem_wdata_o,
  input  logic               mem_ready_i,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [ADDR_W-1:0]  rsp_paddr_o,
  output logic               rsp_fault_o,
  output logic [2:0]         rsp_fcode_o,
  output logic [ADDR_W-1:0]  fault_addr_o
);
  logic [FRAME_W-1:0] base_frame;
  fault_code_t        fcode;

  pw_dir_base #(.FRAME_W(FRAME_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .frame_o (base_frame)
  );

  pw_walker #(.IDX_W(IDX_W)) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .paging_en_i  (paging_en_i),
    .base_i       (base_frame),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_laddr_i  (req_laddr_i),
    .req_write_i  (req_write_i),
    .req_user_i   (req_user_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rdata_i  (mem_rdata_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_fault_o  (rsp_fault_o),
    .rsp_fcode_o  (fcode),
    .fault_addr_o (fault_addr_o)
  );

  assign rsp_fcode_o = fcode;
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        paging_en, base_we;
  logic [19:0] base_wdata;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_laddr;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_ready, rsp_fault;
  logic [31:0] rsp_paddr, fault_addr;
  logic [2:0]  rsp_fcode;

  always #2.5 clk = ~clk;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .paging_en_i(paging_en),
    .base_we_i(base_we), .base_wdata_i(base_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_laddr_i(req_laddr),
    .req_write_i(req_write), .req_user_i(req_user),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_fcode_o(rsp_fcode), .fault_addr_o(fault_addr)
  );

  // memory model: 16 KB, W wait cycles per access
  logic [31:0] mem [0:4095];
  int          wait_states = 0;
  int          wcnt = 0;
  int          log_n = 0;
  logic [31:0] lg_addr [0:15];
  logic        lg_we   [0:15];
  logic [31:0] lg_wd   [0:15];

  assign mem_ready = mem_req && (wcnt == wait_states);
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    if (mem_req && mem_ready) begin
      wcnt <= 0;
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      lg_addr[log_n[3:0]] <= mem_addr;
      lg_we[log_n[3:0]]   <= mem_we;
      lg_wd[log_n[3:0]]   <= mem_wdata;
      log_n <= log_n + 1;
    end
  end

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected access list
  logic [31:0] ex_addr [0:3];
  logic        ex_we   [0:3];
  logic [31:0] ex_wd   [0:3];
  int          ex_n;

  task automatic add_exp(input logic [31:0] a, input logic w, input logic [31:0] d);
    ex_addr[ex_n] = a; ex_we[ex_n] = w; ex_wd[ex_n] = d; ex_n++;
  endtask

  // transaction results
  logic [31:0] r_paddr, r_faddr;
  logic        r_fault;
  logic [2:0]  r_fcode;
  int          r_lat, log_start;

  task automatic txn(input logic [31:0] la, input logic w, input logic u, input int hold);
    log_start = log_n;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 idle before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_laddr = la; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0;
    while (!rsp_valid && r_lat < 2000) begin @(negedge clk); r_lat++; end
    r_paddr = rsp_paddr; r_fault = rsp_fault; r_fcode = rsp_fcode; r_faddr = fault_addr;
    for (int h = 0; h < hold; h++) begin
      req_valid = 1'b1; req_laddr = ~la; req_write = ~w; req_user = ~u;
      @(negedge clk);
      check(rsp_valid && rsp_paddr == r_paddr && rsp_fault == r_fault && rsp_fcode == r_fcode,
            "R11 response held", rsp_paddr, r_paddr);
      check(!req_ready, "R11 busy while response pending", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R11 released after take", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic check_log(input string tag);
    check(log_n - log_start == ex_n, {tag, " access count"}, log_n - log_start, ex_n);
    for (int k = 0; k < ex_n && k < log_n - log_start; k++) begin
      int s = (log_start + k) % 16;
      check(lg_addr[s] == ex_addr[k], {tag, " access address"}, lg_addr[s], ex_addr[k]);
      check(lg_we[s] == ex_we[k], {tag, " access direction"}, {31'd0, lg_we[s]}, {31'd0, ex_we[k]});
      if (ex_we[k]) check(lg_wd[s] == ex_wd[k], {tag, " write-back data"}, lg_wd[s], ex_wd[k]);
    end
  endtask

  // sweep working variables
  logic [1:0]  pr, tr, acc;
  logic        pa, ta, td, allow, w, u;
  logic [9:0]  di, ti;
  logic [11:0] off;
  logic [31:0] tbl, pde, pte, la, frame, prev_fa, dir_ea, tbl_ea;
  int          steps;

  initial begin
    rst_n = 1'b0; paging_en = 1'b0; base_we = 1'b0; base_wdata = '0;
    req_valid = 1'b0; req_laddr = '0; req_write = 1'b0; req_user = 1'b0; rsp_ready = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready && !rsp_valid && !mem_req, "R1 reset handshake state",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
    check(fault_addr == 32'd0, "R1 reset fault address", fault_addr, 32'd0);

    // R3: directory at frame 1 (byte 0x1000)
    base_we = 1'b1; base_wdata = 20'h00001;
    @(negedge clk);
    base_we = 1'b0;

    // R2 pass-through sweep
    for (int i = 0; i < 16; i++) begin
      la = (i * 32'h1111_1111) ^ 32'h0F0F_A5A5;
      ex_n = 0;
      txn(la, i[0], i[1], 0);
      check(r_paddr == la && !r_fault, "R2 pass-through address", r_paddr, la);
      check(r_lat == 0, "R2 pass-through latency", r_lat, 0);
      check_log("R2");
    end

    paging_en = 1'b1;
    prev_fa = fault_addr;
    // R3 R4 R5 R7 R8 R9 R10: sweep of rights, access kinds and status bits
    for (int c = 0; c < 64; c++) begin
      pr = c[5:4]; tr = c[3:2]; acc = c[1:0];
      w = acc[0]; u = acc[1];
      pa = pr[0] ^ acc[0]; ta = tr[1] ^ acc[1]; td = pr[1];
      di = 10'd1 + {9'd0, c[2]};
      tbl = c[2] ? 32'h3000 : 32'h2000;
      ti = 10'((c * 13) % 1024);
      off = 12'((c * 37) & 12'hFFF);
      frame = 32'h40000 + c * 3;
      la = {di, ti, off};
      pde = tbl | ({31'd0, pa} << 5) | ({31'd0, pr[1]} << 2) | ({31'd0, pr[0]} << 1) | 32'd1;
      pte = (frame << 12) | (32'(c[2:0]) << 9) | ({31'd0, td} << 6) | ({31'd0, ta} << 5) |
            ({31'd0, tr[1]} << 2) | ({31'd0, tr[0]} << 1) | 32'd1;
      dir_ea = 32'h1000 + {20'd0, di, 2'b00};
      tbl_ea = tbl + {20'd0, ti, 2'b00};
      mem[dir_ea[13:2]] = pde;
      mem[tbl_ea[13:2]] = pte;
      allow = !u || (pr[1] && tr[1] && (!w || (pr[0] && tr[0])));
      ex_n = 0;
      add_exp(dir_ea, 1'b0, 32'd0);
      if (!pa) add_exp(dir_ea, 1'b1, pde | 32'h20);
      add_exp(tbl_ea, 1'b0, 32'd0);
      if (allow && (!ta || (w && !td))) add_exp(tbl_ea, 1'b1, pte | 32'h20 | (w ? 32'h40 : 32'h0));
      steps = ex_n;
      txn(la, w, u, 0);
      if (allow) begin
        check(!r_fault && r_paddr == ((frame << 12) | {20'd0, off}), "R4 translated address", r_paddr, (frame << 12) | {20'd0, off});
        check(r_fcode == 3'b000, "R8 success code", {29'd0, r_fcode}, 32'd0);
        check(r_faddr == prev_fa, "R8 fault address held", r_faddr, prev_fa);
      end else begin
        check(r_fault && r_paddr == 32'd0, "R7 rights violation faults", {31'd0, r_fault}, 32'd1);
        check(r_fcode == {u, w, 1'b1}, "R8 protection code", {29'd0, r_fcode}, {29'd0, u, w, 1'b1});
        check(r_faddr == la, "R8 fault address latched", r_faddr, la);
        prev_fa = la;
      end
      check(r_lat == steps, "R10 walk latency", r_lat, steps);
      check_log("R9 walk sequence");
    end

    // R6 directory entry not present
    mem[12'h403] = 32'h0000_2000;
    la = {10'd3, 10'd7, 12'h123};
    ex_n = 0; add_exp(32'h100C, 1'b0, 32'd0);
    txn(la, 1'b1, 1'b1, 0);
    check(r_fault && r_fcode == 3'b110, "R6 directory not present", {29'd0, r_fcode}, 32'h6);
    check(r_faddr == la, "R8 fault address on missing directory entry", r_faddr, la);
    check_log("R6 directory stop");

    // R6 table entry not present
    mem[12'h401] = 32'h0000_2027;
    mem[12'h809] = 32'hDEAD_B066;
    la = {10'd1, 10'd9, 12'hFFF};
    ex_n = 0; add_exp(32'h1004, 1'b0, 32'd0); add_exp(32'h2024, 1'b0, 32'd0);
    txn(la, 1'b0, 1'b0, 0);
    check(r_fault && r_fcode == 3'b000, "R6 table not present", {29'd0, r_fcode}, 32'h0);
    check_log("R6 table stop");

    // R10 R12 with two wait cycles per access, full four-step walk
    wait_states = 2;
    mem[12'h402] = 32'h0000_3007;
    mem[12'hC10] = 32'h1234_5007;
    la = {10'd2, 10'd16, 12'h0AB};
    ex_n = 0;
    add_exp(32'h1008, 1'b0, 32'd0); add_exp(32'h1008, 1'b1, 32'h0000_3027);
    add_exp(32'h3040, 1'b0, 32'd0); add_exp(32'h3040, 1'b1, 32'h1234_5067);
    txn(la, 1'b1, 1'b0, 0);
    check(!r_fault && r_paddr == 32'h1234_50AB, "R12 walk with wait states", r_paddr, 32'h1234_50AB);
    check(r_lat == 12, "R10 latency with wait states", r_lat, 12);
    check_log("R12 wait-state sequence");
    wait_states = 0;

    // R11 response held, competing request ignored; entries now have A and D set
    ex_n = 0; add_exp(32'h1008, 1'b0, 32'd0); add_exp(32'h3040, 1'b0, 32'd0);
    txn(la, 1'b1, 1'b0, 3);
    check(r_paddr == 32'h1234_50AB && r_lat == 2, "R11 held response value", r_paddr, 32'h1234_50AB);
    check_log("R11 hold sequence");
    log_start = log_n;
    repeat (2) @(negedge clk);
    check(log_n == log_start && !rsp_valid, "R11 offered request ignored", log_n - log_start, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule